// File: doc/BRIEF.md
# Wireless Transmit Slot Phase Timer

This block runs the timing of a single transmit slot in a wireless MAC. A start pulse names the slot by a 12-bit halfword index into packet RAM. The block then reads the frame header through a synchronous memory port to learn the rate and the payload length. It writes the current transmit sequence number into the frame and times the frame in two phases, preamble then payload. Each phase counts a one-microsecond tick and never counts clock cycles.

The end of the preamble raises a one-cycle interrupt and advances a 12-bit sequence counter. The end of the payload writes a completion status into the header, releases the slot and raises a second one-cycle interrupt. The sequence counter can be loaded while the slot is idle. The memory port has a read latency of one cycle, byte-lane write strobes, and byte addresses of 13 bits that wrap.

Top module: `txslot_timer`

## Requirements
- R1: After reset, `busy`, `irq_pre`, `irq_done` and `mem_req` are 0 and `seq_num` is 0.
- R2: A `start` pulse while idle sets `busy` in the next cycle. The slot's byte address is `slot_base` shifted left by one. The block reads the halfword at byte offset 0 (rate word) and then the halfword at byte offset 0xA (length word).
- R3: A rate word equal to 0x0014 selects the fast rate (2 Mbps). Every other value, including 0x0114, selects the slow rate (1 Mbps).
- R4: The preamble lasts 192 ticks at the slow rate. At the fast rate it lasts 96 ticks when `short_pre` is 1 and 192 ticks when it is 0. `irq_pre` pulses in the cycle after the clock edge that sampled the last preamble tick.
- R5: The payload lasts length×8 ticks at the slow rate and length×4 ticks at the fast rate, where length is bits 13:0 of the length word and bits 15:14 are ignored. A length of zero ends on the first payload tick. `irq_done` pulses three cycles after the edge that sampled the final payload tick.
- R6: `seq_num` increments modulo 4096 in the same cycle that `irq_pre` rises, so 0xFFF is followed by 0x000.
- R7: Before the preamble is timed, the block writes the halfword `seq_num << 4` to byte offset 34 (0xC+22) of the slot.
- R8: On completion the block writes 0x0001 to the halfword at byte offset 0 and clears byte offset 5, the upper lane of halfword 4, while byte 4 keeps its value. `busy` falls in the same cycle that `irq_done` pulses.
- R9: A `start` pulse while `busy` is 1 is ignored. The running frame completes at its own address and no new frame begins.
- R10: `seq_wr_en` loads `seq_wr_val` into `seq_num` when the block is idle and is ignored while `busy` is 1.
- R11: `irq_pre` and `irq_done` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-microsecond timing tick, one cycle wide |
| start | input | 1 | Begin timing the slot |
| slot_base | input | 12 | Slot halfword index in packet RAM |
| short_pre | input | 1 | Short preamble enable for the fast rate |
| seq_wr_en | input | 1 | Load the sequence counter (idle only) |
| seq_wr_val | input | 12 | Value to load into the sequence counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Memory byte address (bit 0 always 0) |
| mem_wstrb | output | 2 | Byte-lane write strobes |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after a read request |
| busy | output | 1 | Slot busy |
| irq_pre | output | 1 | Preamble-complete interrupt pulse |
| irq_done | output | 1 | Transmit-complete interrupt pulse |
| seq_num | output | 12 | Transmit sequence counter |

## Verification
Several properties are checked on every cycle: the pulse shape and mutual exclusion of the two interrupts, the modulo step of the sequence counter at the preamble boundary, the counter holding steady otherwise, busy rising on an accepted start, and busy falling together with the completion pulse after the byte-5 clear. Only the bench scenarios can show the rate and preamble decoding, the exact tick counts of each phase (with ticks spaced apart from each other), the header contents written back, and that a start or a sequence load arriving mid-frame leaves no trace.

// File: rtl/txslot_pkg.sv
package txslot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_RATE,
        ST_RD_LEN,
        ST_LATCH,
        ST_WR_SEQ,
        ST_PRE,
        ST_PAY,
        ST_WR_STAT,
        ST_WR_B5
    } slot_state_e;

endpackage

// File: rtl/txslot_dur.sv
module txslot_dur #(
    parameter int LENW      = 14,
    parameter int CW        = LENW + 3,
    parameter int PRE_LONG  = 192,
    parameter int PRE_SHORT = 96
) (
    input  logic            fast,
    input  logic            short_pre,
    input  logic [LENW-1:0] len,
    output logic [CW-1:0]   pre_ticks,
    output logic [CW-1:0]   pay_ticks
);

    always_comb begin
        pre_ticks = (fast && short_pre) ? CW'(PRE_SHORT) : CW'(PRE_LONG);
        pay_ticks = fast ? CW'({len, 2'b00}) : CW'({len, 3'b000});
    end

endmodule

// File: rtl/txslot_phase_cnt.sv
module txslot_phase_cnt #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          tick,
    output logic          expire
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && tick && (cnt_q <= CW'(1));
        cnt_d  = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && tick && cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

endmodule

// File: rtl/txslot_timer.sv
module txslot_timer
    import txslot_pkg::*;
#(
    parameter int          IDXW      = 12,
    parameter int          DW        = 16,
    parameter int          LENW      = 14,
    parameter int          SEQW      = 12,
    parameter int          SEQ_SHIFT = 4,
    parameter int          PRE_LONG  = 192,
    parameter int          PRE_SHORT = 96,
    parameter logic [15:0] RATE_FAST = 16'h0014
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_us,
    input  logic            start,
    input  logic [IDXW-1:0] slot_base,
    input  logic            short_pre,
    input  logic            seq_wr_en,
    input  logic [SEQW-1:0] seq_wr_val,
    output logic            mem_req,
    output logic            mem_we,
    output logic [IDXW:0]   mem_addr,
    output logic [DW/8-1:0] mem_wstrb,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            irq_pre,
    output logic            irq_done,
    output logic [SEQW-1:0] seq_num
);

    localparam int AW      = IDXW + 1;
    localparam int SW      = DW / 8;
    localparam int CW      = LENW + 3;
    localparam int OFS_LEN = 'hA;
    localparam int OFS_SEQ = 'hC + 22;
    localparam int OFS_B45 = 4;

    typedef struct packed {
        slot_state_e     st;
        logic [AW-1:0]   base;
        logic            fast;
        logic [LENW-1:0] len;
        logic [SEQW-1:0] seq;
        logic            irq_pre;
        logic            irq_done;
    } regs_t;

    regs_t d, q;

    logic          cnt_load, cnt_run, cnt_expire;
    logic [CW-1:0] cnt_val, pre_ticks, pay_ticks;

    txslot_dur #(
        .LENW(LENW), .CW(CW), .PRE_LONG(PRE_LONG), .PRE_SHORT(PRE_SHORT)
    ) u_dur (
        .fast      (q.fast),
        .short_pre (short_pre),
        .len       (q.len),
        .pre_ticks (pre_ticks),
        .pay_ticks (pay_ticks)
    );

    txslot_phase_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .run      (cnt_run),
        .tick     (tick_us),
        .expire   (cnt_expire)
    );

    always_comb begin
        d          = q;
        d.irq_pre  = 1'b0;
        d.irq_done = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wstrb  = '0;
        mem_wdata  = '0;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        cnt_run    = (q.st == ST_PRE) || (q.st == ST_PAY);

        unique case (q.st)
            ST_IDLE: begin
                if (seq_wr_en)
                    d.seq = seq_wr_val;
                if (start) begin
                    d.base = {slot_base, 1'b0};
                    d.st   = ST_RD_RATE;
                end
            end
            ST_RD_RATE: begin
                mem_req  = 1'b1;
                mem_addr = q.base;
                d.st     = ST_RD_LEN;
            end
            ST_RD_LEN: begin
                d.fast   = (mem_rdata == DW'(RATE_FAST));
                mem_req  = 1'b1;
                mem_addr = q.base + AW'(OFS_LEN);
                d.st     = ST_LATCH;
            end
            ST_LATCH: begin
                d.len    = mem_rdata[LENW-1:0];
                cnt_load = 1'b1;
                cnt_val  = pre_ticks;
                d.st     = ST_WR_SEQ;
            end
            ST_WR_SEQ: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base + AW'(OFS_SEQ);
                mem_wstrb = '1;
                mem_wdata = DW'(q.seq) << SEQ_SHIFT;
                d.st      = ST_PRE;
            end
            ST_PRE: begin
                if (cnt_expire) begin
                    cnt_load  = 1'b1;
                    cnt_val   = pay_ticks;
                    d.irq_pre = 1'b1;
                    d.seq     = q.seq + SEQW'(1);
                    d.st      = ST_PAY;
                end
            end
            ST_PAY: begin
                if (cnt_expire)
                    d.st = ST_WR_STAT;
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base;
                mem_wstrb = '1;
                mem_wdata = DW'(1);
                d.st      = ST_WR_B5;
            end
            ST_WR_B5: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = q.base + AW'(OFS_B45);
                mem_wstrb  = SW'(2);
                mem_wdata  = '0;
                d.irq_done = 1'b1;
                d.st       = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.base     <= '0;
            q.fast     <= 1'b0;
            q.len      <= '0;
            q.seq      <= '0;
            q.irq_pre  <= 1'b0;
            q.irq_done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign irq_pre  = q.irq_pre;
    assign irq_done = q.irq_done;
    assign seq_num  = q.seq;

endmodule

// File: rtl/txslot_chk.sv
module txslot_chk #(
    parameter int SEQW = 12,
    parameter int SW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            seq_wr_en,
    input logic            busy,
    input logic            irq_pre,
    input logic            irq_done,
    input logic [SEQW-1:0] seq_num,
    input logic            mem_req,
    input logic            mem_we,
    input logic [SW-1:0]   mem_wstrb
);

    AST_IRQ_PRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pre |=> !irq_pre); // R11
    AST_IRQ_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done); // R11
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_pre && irq_done)); // R11
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pre |-> (seq_num == SEQW'($past(seq_num) + 1'b1))); // R6
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pre && !$past(seq_wr_en && !busy)) |-> $stable(seq_num)); // R10
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (!busy && $past(busy))); // R8
    AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(mem_req && mem_we && mem_wstrb == SW'(2))); // R8

endmodule

bind txslot_timer txslot_chk #(.SEQW(SEQW), .SW(DW/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .seq_wr_en (seq_wr_en),
    .busy      (busy),
    .irq_pre   (irq_pre),
    .irq_done  (irq_done),
    .seq_num   (seq_num),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_wstrb (mem_wstrb)
);

// File: tb/txslot_timer_tb.sv
`timescale 1ns/1ps
module txslot_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        start = 1'b0;
    logic [11:0] slot_base = '0;
    logic        short_pre = 1'b0;
    logic        seq_wr_en = 1'b0;
    logic [11:0] seq_wr_val = '0;
    logic        mem_req, mem_we;
    logic [12:0] mem_addr;
    logic [1:0]  mem_wstrb;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        busy, irq_pre, irq_done;
    logic [11:0] seq_num;

    logic [15:0] mem [0:4095];

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    txslot_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .start(start),
        .slot_base(slot_base), .short_pre(short_pre),
        .seq_wr_en(seq_wr_en), .seq_wr_val(seq_wr_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .irq_pre(irq_pre), .irq_done(irq_done), .seq_num(seq_num)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_wstrb[0]) mem[mem_addr[12:1]][7:0]  <= mem_wdata[7:0];
                if (mem_wstrb[1]) mem[mem_addr[12:1]][15:8] <= mem_wdata[15:8];
            end else begin
                mem_rdata <= mem[mem_addr[12:1]];
            end
        end
    end

    typedef struct packed {
        logic [11:0] idx;
        logic [15:0] rate;
        logic [15:0] lenw;
        logic        sp;
        logic [15:0] exp_pre;
        logic [15:0] exp_pay;
    } vec_t;

    // slot index, rate word, length word, short preamble, preamble ticks, payload ticks
    localparam vec_t VECS [8] = '{
        '{12'h010, 16'h000A, 16'h0003, 1'b0, 16'd192, 16'd24},
        '{12'h020, 16'h0014, 16'h0003, 1'b0, 16'd192, 16'd12},
        '{12'h030, 16'h0014, 16'h0005, 1'b1, 16'd96,  16'd20},
        '{12'h040, 16'h000A, 16'h0002, 1'b1, 16'd192, 16'd16},
        '{12'h050, 16'h0114, 16'h0001, 1'b1, 16'd192, 16'd8},
        '{12'h060, 16'h0014, 16'hC006, 1'b1, 16'd96,  16'd24},
        '{12'h700, 16'h0014, 16'h0000, 1'b1, 16'd96,  16'd1},
        '{12'h080, 16'h0014, 16'h0014, 1'b0, 16'd192, 16'd80}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [11:0] idx, input logic [15:0] rate,
                             input logic [15:0] lenw, input logic sp,
                             input int exp_pre, input int exp_pay,
                             input bit disturb);
        int ticks = 0, pre_at = -1, done_at = -1, pre_w = 0, done_w = 0;
        logic [11:0] seq0;
        int other = (int'(idx) + 'h100) % 4096;
        mem[idx]        = rate;
        mem[idx + 12'd2]  = 16'hABCD;
        mem[idx + 12'd5]  = lenw;
        mem[idx + 12'd17] = 16'h5555;
        mem[other]      = 16'h7777;
        seq0 = seq_num;
        start = 1'b1; slot_base = idx; short_pre = sp;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", busy, 1);
        repeat (6) @(negedge clk);
        while (done_at < 0 && ticks < 3000) begin
            tick_us = 1'b1;
            @(negedge clk);
            tick_us = 1'b0;
            ticks++;
            for (int c = 0; c < 4; c++) begin
                if (irq_pre) begin pre_w++; pre_at = ticks; end
                if (irq_done) begin done_w++; done_at = ticks; end
                if (disturb && pre_at >= 0 && ticks - pre_at == 2 && c == 0) begin
                    start = 1'b1; slot_base = 12'(other);
                    seq_wr_en = 1'b1; seq_wr_val = 12'h123;
                end else begin
                    start = 1'b0; seq_wr_en = 1'b0;
                end
                @(negedge clk);
            end
        end
        chk("R3/R4 preamble ticks", pre_at, exp_pre);
        chk("R5 payload ticks", done_at - pre_at, exp_pay);
        chk("R11 irq_pre width", pre_w, 1);
        chk("R11 irq_done width", done_w, 1);
        chk("R6 seq increment", seq_num, int'(12'(seq0 + 12'd1)));
        chk("R7 seq field in frame", mem[idx + 12'd17], int'({seq0, 4'h0}));
        chk("R8 status word", mem[idx], 1);
        chk("R8 byte 5 cleared, byte 4 kept", mem[idx + 12'd2], 'h00CD);
        chk("R8 busy released", busy, 0);
        if (disturb) begin
            repeat (10) @(negedge clk);
            chk("R9 no frame at second base", mem[other], 'h7777);
            chk("R9 no restart", busy, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 irq_pre", irq_pre, 0);
        chk("R1 irq_done", irq_done, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 seq_num", seq_num, 0);

        for (int v = 0; v < 8; v++)
            run_frame(VECS[v].idx, VECS[v].rate, VECS[v].lenw, VECS[v].sp,
                      int'(VECS[v].exp_pre), int'(VECS[v].exp_pay), 1'b0);

        // R9 and R10: start and sequence load during the payload are ignored
        run_frame(12'h200, 16'h0014, 16'h0004, 1'b1, 96, 16, 1'b1);

        // R10 load while idle, then R6 wrap from 0xFFF
        seq_wr_en = 1'b1; seq_wr_val = 12'hFFF;
        @(negedge clk);
        seq_wr_en = 1'b0;
        chk("R10 idle load", seq_num, 'hFFF);
        run_frame(12'h300, 16'h0014, 16'h0002, 1'b1, 96, 8, 1'b0);
        chk("R6 wrap to zero", seq_num, 0);

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule